// File: doc/BRIEF.md
# Cut Dump Sequencer

This block sits next to the master processor of a multi-core chip and orders the dumping of every core's debug state (its "cut") over one shared bus. A single trigger starts a whole system dump. The sequencer first sends one start strobe to all fixed-schedule accelerator cores. Their dumps follow a static schedule, so the sequencer waits a configured number of cycles and expects no reply from them.

Next, the sequencer gives each slave processor one turn in index order. A grant line starts that slave and also enables its bus driver. The grant is held until the slave acknowledges that its single dump is complete, or until a configured limit expires. In that case the slave's timeout flag is raised and the next slave gets its turn. Last, the sequencer drives the bus with its own state words. It supplies the word index to the bus multiplexer and pulses done when the final word has gone out.

All run-time settings are sampled at the trigger: the slave count, the accelerator wait, the own word count and the acknowledge limit.

Top module: `cut_dump_sequencer`

## Requirements
- R1: While reset is held and directly after it, accel_start_o, slv_grant_o, own_drv_o, busy_o, done_o and slv_timeout_o are all zero.
- R2: A high trig_i seen at a clock edge while idle gives accel_start_o high for exactly the next cycle. busy_o is high from that same cycle on.
- R3: Call the accelerator strobe cycle offset 0 and the configured wait A. The first slave grant starts at offset A+1. With no slaves, the own dump (or, with no own words, done) starts at offset A+1. Accelerator cores return nothing.
- R4: With N slaves configured, slaves 0..N-1 each receive exactly one turn, in ascending index order, and back to back. A configured count above MAX_SLAVES (8) is treated as MAX_SLAVES.
- R5: A grant stays high until the granted slave's ack bit is seen high at a clock edge. The next turn starts in the following cycle. Ack bits of slaves that are not granted have no effect.
- R6: With acknowledge limit T, a turn without an ack ends after T+1 grant cycles and sets that slave's bit in slv_timeout_o. The bit stays set until the next accepted trigger. An ack in the last allowed cycle (grant cycle T) ends the turn without setting the flag.
- R7: In every cycle at most one of the slave grants and own_drv_o is high.
- R8: After the last slave turn, own_drv_o is high for exactly W cycles, with own_word_idx_o counting 0..W-1. With W = 0 the own dump is skipped.
- R9: done_o is high for exactly one cycle, directly after the last own word (or the last earlier phase). The block is idle in the following cycle.
- R10: A trigger while busy, including the done cycle, is ignored, and the running sequence keeps its timing.
- R11: Configuration inputs are sampled only when a trigger is accepted. Changing them during a sequence has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Request to start a system dump |
| cfg_slaves_i | input | SN_W | Number of slave processors that take part |
| cfg_accel_cyc_i | input | ACC_W | Cycles to wait for the accelerator dumps |
| cfg_own_words_i | input | WRD_W | Number of own state words |
| cfg_ack_limit_i | input | TO_W | Acknowledge limit T per slave turn |
| accel_start_o | output | 1 | One-cycle start strobe to all accelerators |
| slv_grant_o | output | MAX_SLAVES | Per-slave start and bus drive enable |
| slv_ack_i | input | MAX_SLAVES | Per-slave dump complete acknowledge |
| slv_timeout_o | output | MAX_SLAVES | Per-slave timeout flags of the last sequence |
| own_drv_o | output | 1 | Bus drive enable for the master's own words |
| own_word_idx_o | output | WRD_W | Index of the own word on the bus |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-dump pulse |

## Verification
The bench probes the following corner cases, each paired with the error it would reveal:

- **Ack exactly at the limit:** a design with an off-by-one would flag a good slave or cut its turn short.
- **Zero wait, zero slaves and zero own words:** a design that mishandles these would stall or emit a stray cycle of drive enable.
- **Slave count above the maximum:** the bench checks that out-of-range indices are never granted.
- **Spurious acks during the accelerator wait and from non-participating slaves:** a design that does not gate acks with the grant would end turns early.
- **A second trigger with changed settings mid-sequence:** a design that re-samples its inputs would restart or shift the grant timeline.

// File: rtl/cds_pkg.sv
package cds_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACCEL,
      ST_SLV,
      ST_OWN,
      ST_DONE
   } cds_state_e;

endpackage

// File: rtl/cds_accel_timer.sv
// Down counter that measures the statically scheduled accelerator phase.
module cds_accel_timer #(
   parameter int ACC_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [ACC_W-1:0] len_i,
   input  logic             run_i,
   output logic             expired_o
);

   logic [ACC_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= len_i;
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - ACC_W'(1);
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/cds_slave_poller.sv
// Gives each participating slave one handshaked turn on the bus.
module cds_slave_poller #(
   parameter int MAX_SLAVES = 8,
   parameter int TO_W       = 10,
   parameter bit ROTATE     = 1'b0,
   localparam int SN_W      = $clog2(MAX_SLAVES + 1),
   localparam int SI_W      = $clog2(MAX_SLAVES)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  begin_i,
   input  logic [SN_W-1:0]       n_i,
   input  logic [TO_W-1:0]       limit_i,
   input  logic                  active_i,
   input  logic [MAX_SLAVES-1:0] ack_i,
   output logic [MAX_SLAVES-1:0] grant_o,
   output logic                  last_o,
   output logic                  none_o,
   output logic [MAX_SLAVES-1:0] err_o
);

   logic [SN_W-1:0]       n_q;
   logic [TO_W-1:0]       limit_q;
   logic [SI_W-1:0]       cur_q;
   logic [SN_W-1:0]       left_q;
   logic [TO_W-1:0]       tcnt_q;
   logic [MAX_SLAVES-1:0] err_q;
   logic [SI_W-1:0]       first_idx;
   logic                  ack_cur;
   logic                  expire;
   logic                  finish;

   function automatic logic [SI_W-1:0] step_idx(input logic [SI_W-1:0] idx,
                                                input logic [SN_W-1:0] n);
      if (int'(idx) + 1 >= int'(n)) return '0;
      return idx + SI_W'(1);
   endfunction

   generate
      if (ROTATE) begin : g_rotate
         logic [SI_W-1:0] rot_q;
         assign first_idx = (int'(rot_q) < int'(n_i)) ? rot_q : '0;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               rot_q <= '0;
            end else if (begin_i && (n_i != '0)) begin
               rot_q <= step_idx(first_idx, n_i);
            end
         end
      end else begin : g_fixed
         assign first_idx = '0;
      end
   endgenerate

   assign ack_cur = ack_i[cur_q];
   assign expire  = (tcnt_q == limit_q);
   assign finish  = active_i && (ack_cur || expire);
   assign last_o  = finish && (left_q == SN_W'(1));
   assign none_o  = (n_q == '0);
   assign err_o   = err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         n_q     <= '0;
         limit_q <= '0;
         cur_q   <= '0;
         left_q  <= '0;
         tcnt_q  <= '0;
         err_q   <= '0;
      end else if (begin_i) begin
         n_q     <= n_i;
         limit_q <= limit_i;
         cur_q   <= first_idx;
         left_q  <= n_i;
         tcnt_q  <= '0;
         err_q   <= '0;
      end else if (finish) begin
         if (!ack_cur) err_q[cur_q] <= 1'b1;
         cur_q  <= step_idx(cur_q, n_q);
         left_q <= left_q - SN_W'(1);
         tcnt_q <= '0;
      end else if (active_i) begin
         tcnt_q <= tcnt_q + TO_W'(1);
      end
   end

   generate
      for (genvar g = 0; g < MAX_SLAVES; g++) begin : g_grant
         assign grant_o[g] = active_i && (cur_q == SI_W'(g));
      end
   endgenerate

endmodule

// File: rtl/cds_own_dump.sv
// Walks the master's own state words in index order.
module cds_own_dump #(
   parameter int WRD_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             begin_i,
   input  logic [WRD_W-1:0] cnt_i,
   input  logic             active_i,
   output logic [WRD_W-1:0] idx_o,
   output logic             last_o,
   output logic             empty_o
);

   logic [WRD_W-1:0] cnt_q;
   logic [WRD_W-1:0] idx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         idx_q <= '0;
      end else if (begin_i) begin
         cnt_q <= cnt_i;
         idx_q <= '0;
      end else if (active_i) begin
         idx_q <= idx_q + WRD_W'(1);
      end
   end

   assign idx_o   = active_i ? idx_q : '0;
   assign last_o  = active_i && (idx_q == cnt_q - WRD_W'(1));
   assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/cut_dump_sequencer.sv
module cut_dump_sequencer
   import cds_pkg::*;
#(
   parameter int MAX_SLAVES = 8,
   parameter int ACC_W      = 12,
   parameter int WRD_W      = 8,
   parameter int TO_W       = 10,
   parameter bit ROTATE     = 1'b0,
   localparam int SN_W      = $clog2(MAX_SLAVES + 1)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  trig_i,
   input  logic [SN_W-1:0]       cfg_slaves_i,
   input  logic [ACC_W-1:0]      cfg_accel_cyc_i,
   input  logic [WRD_W-1:0]      cfg_own_words_i,
   input  logic [TO_W-1:0]       cfg_ack_limit_i,
   output logic                  accel_start_o,
   output logic [MAX_SLAVES-1:0] slv_grant_o,
   input  logic [MAX_SLAVES-1:0] slv_ack_i,
   output logic [MAX_SLAVES-1:0] slv_timeout_o,
   output logic                  own_drv_o,
   output logic [WRD_W-1:0]      own_word_idx_o,
   output logic                  busy_o,
   output logic                  done_o
);

   initial begin
      if (MAX_SLAVES < 2 || MAX_SLAVES > 8)
         $error("cut_dump_sequencer: MAX_SLAVES must lie in 2..8");
      if (ACC_W < 1 || WRD_W < 1 || TO_W < 1)
         $error("cut_dump_sequencer: counter widths must be positive");
   end

   cds_state_e      state_q, state_d;
   logic            launch;
   logic            start_q;
   logic [SN_W-1:0] n_clamped;
   logic            acc_expired;
   logic            poll_last;
   logic            poll_none;
   logic            own_last;
   logic            own_empty;

   assign launch    = (state_q == ST_IDLE) && trig_i;
   assign n_clamped = (cfg_slaves_i > SN_W'(MAX_SLAVES)) ? SN_W'(MAX_SLAVES) : cfg_slaves_i;

   cds_accel_timer #(.ACC_W(ACC_W)) i_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (launch),
      .len_i     (cfg_accel_cyc_i),
      .run_i     (state_q == ST_ACCEL),
      .expired_o (acc_expired)
   );

   cds_slave_poller #(
      .MAX_SLAVES (MAX_SLAVES),
      .TO_W       (TO_W),
      .ROTATE     (ROTATE)
   ) i_poller (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .begin_i  (launch),
      .n_i      (n_clamped),
      .limit_i  (cfg_ack_limit_i),
      .active_i (state_q == ST_SLV),
      .ack_i    (slv_ack_i),
      .grant_o  (slv_grant_o),
      .last_o   (poll_last),
      .none_o   (poll_none),
      .err_o    (slv_timeout_o)
   );

   cds_own_dump #(.WRD_W(WRD_W)) i_own (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .begin_i  (launch),
      .cnt_i    (cfg_own_words_i),
      .active_i (state_q == ST_OWN),
      .idx_o    (own_word_idx_o),
      .last_o   (own_last),
      .empty_o  (own_empty)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (trig_i) state_d = ST_ACCEL;
         ST_ACCEL: if (acc_expired) begin
                      if (!poll_none)     state_d = ST_SLV;
                      else if (own_empty) state_d = ST_DONE;
                      else                state_d = ST_OWN;
                   end
         ST_SLV:   if (poll_last) state_d = own_empty ? ST_DONE : ST_OWN;
         ST_OWN:   if (own_last) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         start_q <= 1'b0;
      end else begin
         state_q <= state_d;
         start_q <= launch;
      end
   end

   assign accel_start_o = start_q;
   assign own_drv_o     = (state_q == ST_OWN);
   assign busy_o        = (state_q != ST_IDLE);
   assign done_o        = (state_q == ST_DONE);

endmodule

// File: rtl/cds_checker.sv
module cds_checker #(
   parameter int MAX_SLAVES = 8
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  accel_start_o,
   input logic [MAX_SLAVES-1:0] slv_grant_o,
   input logic [MAX_SLAVES-1:0] slv_ack_i,
   input logic [MAX_SLAVES-1:0] slv_timeout_o,
   input logic                  own_drv_o,
   input logic                  busy_o,
   input logic                  done_o
);

   // R7
   one_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({slv_grant_o, own_drv_o}));

   // R2
   start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accel_start_o |=> !accel_start_o);

   // R10
   start_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accel_start_o |-> !$past(busy_o));

   // R9
   done_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !busy_o);

   // R5
   ack_ends_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(slv_grant_o & slv_ack_i)) |=> (slv_grant_o != $past(slv_grant_o)));

   // R6
   grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|slv_grant_o) && !(|(slv_grant_o & slv_ack_i))) |=>
         ((slv_grant_o == $past(slv_grant_o)) || (slv_timeout_o != $past(slv_timeout_o))));

endmodule

bind cut_dump_sequencer cds_checker #(.MAX_SLAVES(MAX_SLAVES)) i_cds_checker (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .accel_start_o (accel_start_o),
   .slv_grant_o   (slv_grant_o),
   .slv_ack_i     (slv_ack_i),
   .slv_timeout_o (slv_timeout_o),
   .own_drv_o     (own_drv_o),
   .busy_o        (busy_o),
   .done_o        (done_o)
);

// File: tb/test_cut_dump_sequencer.sv
module test_cut_dump_sequencer;

   localparam int NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig = 1'b0;
   logic [3:0]  cfg_n = '0;
   logic [11:0] cfg_a = '0;
   logic [7:0]  cfg_w = '0;
   logic [9:0]  cfg_t = '0;
   logic        accel_start;
   logic [7:0]  grant;
   logic [7:0]  ack = '0;
   logic [7:0]  tmo;
   logic        own_drv;
   logic [7:0]  own_idx;
   logic        busy;
   logic        done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;
   int dly[NS];

   always #2 clk = ~clk;

   cut_dump_sequencer i_cut_dump_sequencer (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .trig_i          (trig),
      .cfg_slaves_i    (cfg_n),
      .cfg_accel_cyc_i (cfg_a),
      .cfg_own_words_i (cfg_w),
      .cfg_ack_limit_i (cfg_t),
      .accel_start_o   (accel_start),
      .slv_grant_o     (grant),
      .slv_ack_i       (ack),
      .slv_timeout_o   (tmo),
      .own_drv_o       (own_drv),
      .own_word_idx_o  (own_idx),
      .busy_o          (busy),
      .done_o          (done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int turn_len(input int d, input int t);
      return (d >= 0 && d <= t) ? d + 1 : t + 1;
   endfunction

   // cat: 0 start, 1 grant, 2 own, 3 done, 4 busy
   task automatic run_seq(input int n_raw, input int a, input int w, input int t,
                          input bit noise, input bit retrig);
      int n, o, fin, pos;
      int gstart[NS];
      int glen[NS];
      int gcnt[NS];
      int bad[5];
      int bact[5];
      int bexp[5];
      logic [7:0] exp_err;
      n = (n_raw > NS) ? NS : n_raw;
      pos = a + 1;
      exp_err = '0;
      for (int j = 0; j < NS; j++) begin
         gcnt[j] = 0;
         gstart[j] = 0;
         glen[j] = 0;
         if (j < n) begin
            gstart[j] = pos;
            glen[j] = turn_len(dly[j], t);
            pos += glen[j];
            if (!(dly[j] >= 0 && dly[j] <= t)) exp_err[j] = 1'b1;
         end
      end
      o = pos;
      fin = o + w;
      for (int k = 0; k < 5; k++) begin bad[k] = 0; bact[k] = 0; bexp[k] = 0; end

      @(negedge clk);
      cfg_n = 4'(n_raw);
      cfg_a = 12'(a);
      cfg_w = 8'(w);
      cfg_t = 10'(t);
      trig  = 1'b1;
      for (int off = 0; off <= fin + 2; off++) begin
         logic [7:0] eg;
         int act[5];
         int ex[5];
         @(negedge clk);
         if (off == 0) trig = 1'b0;
         if (retrig && off == 1) begin
            // R10 R11: second request with different settings mid-run
            trig  = 1'b1;
            cfg_n = 4'd2;
            cfg_a = 12'd7;
            cfg_w = 8'd9;
            cfg_t = 10'd1;
         end
         if (retrig && off == 2) trig = 1'b0;
         eg = '0;
         for (int j = 0; j < n; j++)
            if (off >= gstart[j] && off < gstart[j] + glen[j]) eg[j] = 1'b1;
         act[0] = int'(accel_start);       ex[0] = (off == 0) ? 1 : 0;
         act[1] = int'(grant);             ex[1] = int'(eg);
         act[2] = int'({own_drv, own_idx});
         ex[2]  = (off >= o && off < fin) ? (256 + off - o) : 0;
         act[3] = int'(done);              ex[3] = (off == fin) ? 1 : 0;
         act[4] = int'(busy);              ex[4] = (off <= fin) ? 1 : 0;
         for (int k = 0; k < 5; k++)
            if (act[k] != ex[k] && bad[k] == 0) begin
               bad[k] = off + 1;
               bact[k] = act[k];
               bexp[k] = ex[k];
            end
         for (int i = 0; i < NS; i++) begin
            if (grant[i]) begin
               ack[i] = (gcnt[i] == dly[i]);
               gcnt[i]++;
            end else begin
               gcnt[i] = 0;
               ack[i] = noise && (i >= n || off <= a);
            end
         end
      end
      ack = '0;
      check(bad[0] == 0, "R2", "start strobe trace", bact[0], bexp[0]);
      check(bad[1] == 0, "R3 R4 R5 R6", "grant trace", bact[1], bexp[1]);
      check(bad[2] == 0, "R8", "own dump trace {drv,idx}", bact[2], bexp[2]);
      check(bad[3] == 0, "R9", "done pulse trace", bact[3], bexp[3]);
      check(bad[4] == 0, "R10", "busy trace", bact[4], bexp[4]);
      check(tmo == exp_err, "R6", "timeout flags", int'(tmo), int'(exp_err));
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check({accel_start, grant, own_drv, busy, done, tmo} == '0, "R1", "outputs in reset",
            int'({accel_start, grant, own_drv, busy, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({accel_start, grant, own_drv, busy, done, tmo} == '0, "R1", "outputs after reset",
            int'({accel_start, grant, own_drv, busy, done}), 0);

      // normal flow, acks inside the limit
      dly = '{0, 2, 5, 1, 0, 0, 0, 0};
      run_seq(3, 4, 3, 5, 1'b0, 1'b0);
      // R6: ack exactly at limit, one silent slave, one late slave
      dly = '{3, -1, 9, 0, 0, 0, 0, 0};
      run_seq(3, 2, 2, 3, 1'b0, 1'b0);
      // R3 R8 R9: zero wait, no slaves, no own words
      run_seq(0, 0, 0, 2, 1'b0, 1'b0);
      // R4: count above maximum is clamped
      dly = '{0, 1, 0, 2, 0, 1, 0, 3};
      run_seq(9, 1, 1, 4, 1'b0, 1'b0);
      // R5 R10 R11: spurious acks and a second trigger mid-run
      dly = '{1, 0, 2, 0, 0, 0, 0, 0};
      run_seq(3, 3, 2, 4, 1'b1, 1'b1);
      // R2 R9: tiny run with a retrigger landing in the done cycle
      run_seq(0, 0, 0, 0, 1'b1, 1'b1);
      // single slave, zero limit, ack immediately
      dly = '{0, 0, 0, 0, 0, 0, 0, 0};
      run_seq(1, 0, 1, 0, 1'b0, 1'b0);

      for (int r = 0; r < 8; r++) begin
         int rn, ra, rw, rt;
         rn = int'($urandom_range(0, 9));
         ra = int'($urandom_range(0, 20));
         rw = int'($urandom_range(0, 10));
         rt = int'($urandom_range(0, 8));
         for (int i = 0; i < NS; i++) dly[i] = int'($urandom_range(0, 11)) - 1;
         run_seq(rn, ra, rw, rt, r[0], r[1]);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule